// File: doc/BRIEF.md
# Audio Subframe Packer

The block takes interleaved 24-bit PCM samples for a stream of two to eight channels and turns each one into a 32-bit subframe word. Each word holds the sample, a channel-status bit, an even-parity bit and a flag that marks the first subframe of a status block. The channel-status bits come from a 32-bit consumer header that is loaded once per stream. A frame counter walks through a 192-frame status block. It advances once per complete multichannel frame, not once per sample. For each channel, the block writes that channel's own number into a fixed nibble of the status data.

A second mode passes through words that already carry the subframe flags in their top nibble and a preamble code in their bottom nibble. In this mode the audio moves down to the low bits and the block-start marker moves to bit 28. Both sides are valid/ready streams joined by combinational logic. A word moves only when the input is valid and the output is ready. A stall freezes the frame and channel position.

Top module: `subframe_packer`

## Requirements
- R1: In PCM mode (modeSel = 0), output bits 23:0 equal input bits 23:0. Input bits 31:24 are ignored. Output bits 25:24 (validity, user) and 31:29 are 0.
- R2: In PCM mode, output bit 27 is the parity bit, set so that the XOR of output bits 27:0 is 0.
- R3: Output bit 26 carries the status bit of the current frame n. For n < 32 it is header bit n: header byte k sits in hdrData bits 8k+7:8k, so the bit is byte n/8, bit n%8. For n >= 32 it is 0.
- R4: For frames 20 to 23 (bits 7:4 of status byte 2), the status bit is instead bit (n-20) of the channel index plus one, so channel 0 reports 1 and channel 7 reports 8.
- R5: Output bit 28 is 1 in PCM mode only for channel 0 of frame 0.
- R6: The channel index runs from 0 to numCh-1. The frame index advances once after the last channel of a frame and wraps from 191 to 0.
- R7: In pass-through mode (modeSel = 1), output bits 27:0 equal input bits 31:4, output bit 28 equals input bit 3, and bits 31:29 are 0.
- R8: outValid follows inValid and inReady follows outReady. The frame and channel position changes only on a cycle with inValid and outReady both high.
- R9: A cycle with hdrLoad or start high resets the frame and channel index to 0. hdrLoad stores hdrData on that same edge, and the new header applies to every later word.
- R10: A numCh below 2 acts as 2 channels, and a numCh above 8 acts as 8 channels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| modeSel | input | 1 | 0 = PCM packing, 1 = pass-through of pre-formatted words |
| numCh | input | 4 | Channels per frame (2 to 8) |
| hdrLoad | input | 1 | Store hdrData as the status header and restart the block |
| hdrData | input | 32 | Consumer status header, byte 0 in the low bits |
| start | input | 1 | Restart the block at frame 0, channel 0 |
| inValid | input | 1 | Input word valid |
| inData | input | 32 | Input sample or pre-formatted word |
| inReady | output | 1 | Input word accepted when high together with inValid |
| outValid | output | 1 | Output word valid |
| outData | output | 32 | Packed subframe word |
| outReady | input | 1 | Downstream can take a word |

## Verification
The bench covers these corner cases:

- **Frame-counter wrap.** It runs more than a full 192-frame block, so a counter that wraps at the wrong count shows up as a second block-start flag in the wrong place or as header bits on late frames.
- **Channel-number nibble.** It checks frames 20 to 23 on every channel, including channel 7, so a design that numbers channels from zero, or leaves the header nibble in place, gives wrong status bits there.
- **Stalls.** It holds outReady low while input is waiting, so a design that counts on inValid alone skips a channel.
- **Restarts and header reloads.** It restarts and reloads the header in the middle of a block, which exposes a design that keeps its old position or delays the new header.
- **Channel counts out of range.** It drives counts below 2 and above 8, which exposes a design without clamping that runs the wrong frame length.
- **Pass-through mode.** It checks pass-through with each preamble code, which catches a bit mapped to the wrong place.

// File: rtl/sfp_pkg.sv
package sfp_pkg;
  localparam int FRAMES    = 192;
  localparam int MAX_CH    = 8;
  localparam int HDR_BYTES = 4;
  localparam int WORD_W    = 32;
  localparam int SAMPLE_W  = 24;

  localparam int FRM_W  = $clog2(FRAMES);
  localparam int CH_W   = $clog2(MAX_CH);
  localparam int NCH_W  = $clog2(MAX_CH + 1);
  localparam int HDR_W  = 8 * HDR_BYTES;
  localparam int HIDX_W = $clog2(HDR_W);
  localparam int CHAN_LO = 20;   // status byte 2, upper nibble

  typedef enum logic {
    MODE_PCM  = 1'b0,
    MODE_PASS = 1'b1
  } mode_e;

  typedef struct packed {
    logic             firstSlot;
    logic [FRM_W-1:0] frameIdx;
    logic [CH_W-1:0]  chIdx;
  } slot_t;
endpackage

// File: rtl/sfp_seq.sv
module sfp_seq
  import sfp_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NCH_W-1:0] numCh,
  input  logic             restart,
  input  logic             accept,
  output slot_t            slot
);
  logic [FRM_W-1:0] frameQ;
  logic [CH_W-1:0]  chQ;
  logic [CH_W-1:0]  lastCh;

  always_comb begin
    if (numCh < NCH_W'(2))
      lastCh = CH_W'(1);
    else if (numCh > NCH_W'(MAX_CH))
      lastCh = CH_W'(MAX_CH - 1);
    else
      lastCh = CH_W'(numCh - NCH_W'(1));
  end

  always_ff @(posedge clk) begin
    if (!rst_n || restart) begin
      frameQ <= '0;
      chQ    <= '0;
    end else if (accept) begin
      if (chQ == lastCh) begin
        chQ    <= '0;
        frameQ <= (frameQ == FRM_W'(FRAMES - 1)) ? '0 : frameQ + FRM_W'(1);
      end else begin
        chQ <= chQ + CH_W'(1);
      end
    end
  end

  always_comb begin
    slot.frameIdx  = frameQ;
    slot.chIdx     = chQ;
    slot.firstSlot = (frameQ == '0) && (chQ == '0);
  end
endmodule

// File: rtl/sfp_pack.sv
module sfp_pack
  import sfp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hdrLoad,
  input  logic [HDR_W-1:0]  hdrData,
  input  logic              modeSel,
  input  logic [WORD_W-1:0] inData,
  input  slot_t             slot,
  output logic [WORD_W-1:0] outData
);
  logic [HDR_W-1:0] hdrQ;
  logic [3:0]       chNum;
  logic             csBit;
  logic [26:0]      lowBits;
  logic             parityBit;
  mode_e            mode;

  always_ff @(posedge clk) begin
    if (!rst_n)
      hdrQ <= '0;
    else if (hdrLoad)
      hdrQ <= hdrData;
  end

  assign chNum = 4'(slot.chIdx) + 4'd1;
  assign mode  = mode_e'(modeSel);

  always_comb begin
    csBit = 1'b0;
    if (slot.frameIdx < FRM_W'(HDR_W)) begin
      if (slot.frameIdx >= FRM_W'(CHAN_LO) && slot.frameIdx < FRM_W'(CHAN_LO + 4))
        csBit = chNum[slot.frameIdx[1:0]];
      else
        csBit = hdrQ[slot.frameIdx[HIDX_W-1:0]];
    end
  end

  assign lowBits   = {csBit, 2'b00, inData[SAMPLE_W-1:0]};
  assign parityBit = ^lowBits;

  always_comb begin
    if (mode == MODE_PASS)
      outData = {3'b000, inData[3], inData[WORD_W-1:4]};
    else
      outData = {3'b000, slot.firstSlot, parityBit, lowBits};
  end
endmodule

// File: rtl/subframe_packer.sv
module subframe_packer
  import sfp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              modeSel,
  input  logic [NCH_W-1:0]  numCh,
  input  logic              hdrLoad,
  input  logic [HDR_W-1:0]  hdrData,
  input  logic              start,
  input  logic              inValid,
  input  logic [WORD_W-1:0] inData,
  output logic              inReady,
  output logic              outValid,
  output logic [WORD_W-1:0] outData,
  input  logic              outReady
);
  slot_t slotBus;
  logic  accept;

  assign accept   = inValid && outReady;
  assign inReady  = outReady;
  assign outValid = inValid;

  sfp_seq u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .numCh   (numCh),
    .restart (hdrLoad || start),
    .accept  (accept),
    .slot    (slotBus)
  );

  sfp_pack u_pack (
    .clk     (clk),
    .rst_n   (rst_n),
    .hdrLoad (hdrLoad),
    .hdrData (hdrData),
    .modeSel (modeSel),
    .inData  (inData),
    .slot    (slotBus),
    .outData (outData)
  );
endmodule

// File: rtl/subframe_packer_chk.sv
module subframe_packer_chk
  import sfp_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              modeSel,
  input logic              hdrLoad,
  input logic              start,
  input logic              inValid,
  input logic [WORD_W-1:0] inData,
  input logic              outReady,
  input logic [WORD_W-1:0] outData,
  input slot_t             slot
);
  // R1
  pcm_layout_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inValid && !modeSel) |-> (outData[31:29] == 3'b000 && outData[25:24] == 2'b00
                               && outData[23:0] == inData[23:0]));

  // R2
  parity_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inValid && !modeSel) |-> (^outData[27:0] == 1'b0));

  // R5
  block_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inValid && !modeSel && outData[28]) |-> (slot.frameIdx == '0 && slot.chIdx == '0));

  // R6
  frame_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    slot.frameIdx <= FRM_W'(FRAMES - 1));

  // R7
  pass_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inValid && modeSel) |-> (outData[27:0] == inData[31:4] && outData[28] == inData[3]
                              && outData[31:29] == 3'b000));

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!(inValid && outReady) && !hdrLoad && !start) |=> $stable(slot));

  // R9
  restart_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hdrLoad || start) |=> (slot.frameIdx == '0 && slot.chIdx == '0));
endmodule

bind subframe_packer subframe_packer_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .modeSel  (modeSel),
  .hdrLoad  (hdrLoad),
  .start    (start),
  .inValid  (inValid),
  .inData   (inData),
  .outReady (outReady),
  .outData  (outData),
  .slot     (slotBus)
);

// File: tb/sim_subframe_packer.sv
`timescale 1ns/1ps
module sim_subframe_packer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        modeSel = 1'b0;
  logic [3:0]  numCh = 4'd2;
  logic        hdrLoad = 1'b0;
  logic [31:0] hdrData = '0;
  logic        start = 1'b0;
  logic        inValid = 1'b0;
  logic [31:0] inData = '0;
  logic        inReady;
  logic        outValid;
  logic [31:0] outData;
  logic        outReady = 1'b1;

  int checks = 0;
  int fails  = 0;
  logic [31:0] curHdr = '0;

  always #5 clk = ~clk;

  subframe_packer u0 (
    .clk(clk), .rst_n(rst_n), .modeSel(modeSel), .numCh(numCh),
    .hdrLoad(hdrLoad), .hdrData(hdrData), .start(start),
    .inValid(inValid), .inData(inData), .inReady(inReady),
    .outValid(outValid), .outData(outData), .outReady(outReady)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] expWord(input logic [31:0] hdr, input int frame,
                                          input int ch, input logic [31:0] din);
    logic [31:0] h;
    logic [3:0]  num;
    logic        cs;
    logic [26:0] low;
    h = hdr;
    num = 4'(ch + 1);
    h[23:20] = num;
    cs = (frame < 32) ? h[frame] : 1'b0;
    low = {cs, 2'b00, din[23:0]};
    return {3'b000, (frame == 0 && ch == 0), ^low, low};
  endfunction

  function automatic logic [31:0] mkSample(input int f, input int c);
    return {8'hA5 ^ 8'(f), 4'(c), 8'(f * 7), 12'(f * 37 + c * 101)};
  endfunction

  task automatic restartBlock();
    @(negedge clk);
    inValid = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic loadHeader(input logic [31:0] h);
    @(negedge clk);
    inValid = 1'b0; hdrLoad = 1'b1; hdrData = h;
    @(negedge clk);
    hdrLoad = 1'b0; curHdr = h;
  endtask

  // streams frames [f0, f0+nf) for nch channels and checks every word
  task automatic streamPcm(input string tag, input int nch, input int f0, input int nf);
    for (int f = f0; f < f0 + nf; f++) begin
      for (int c = 0; c < nch; c++) begin
        @(negedge clk);
        inValid = 1'b1;
        inData  = mkSample(f, c);
        #1;
        check(tag, outData, expWord(curHdr, f % 192, c, inData));
      end
    end
    @(negedge clk);
    inValid = 1'b0;
  endtask

  task automatic testReset();
    check("R8 reset outValid", {31'b0, outValid}, 32'd0);
    check("R8 inReady follows outReady", {31'b0, inReady}, 32'd1);
  endtask

  task automatic testFullBlock();
    // R3 R4 R5 R6 R1 R2: three channels over a wrap
    modeSel = 1'b0; numCh = 4'd3;
    loadHeader(32'h8C3A_5E17);
    streamPcm("R6 wrap/R3 status/R5 start", 3, 0, 194);
  endtask

  task automatic testEightCh();
    // R4: channel number nibble up to 8
    numCh = 4'd8;
    restartBlock();
    streamPcm("R4 channel nibble 8ch", 8, 0, 26);
  endtask

  task automatic testStall();
    // R8: backpressure freezes position
    numCh = 4'd2;
    restartBlock();
    @(negedge clk);
    outReady = 1'b0; inValid = 1'b1; inData = mkSample(0, 0);
    for (int i = 0; i < 3; i++) begin
      #1;
      check("R8 stall word", outData, expWord(curHdr, 0, 0, inData));
      check("R8 stall inReady", {31'b0, inReady}, 32'd0);
      check("R8 outValid follows", {31'b0, outValid}, 32'd1);
      @(negedge clk);
    end
    outReady = 1'b1;
    inValid = 1'b0;
    streamPcm("R8 after stall", 2, 0, 2);
  endtask

  task automatic testRestartMid();
    // R9: start mid-block
    numCh = 4'd2;
    streamPcm("R9 pre", 2, 2, 3);
    restartBlock();
    streamPcm("R9 start resets", 2, 0, 2);
    // R9: header reload mid-block with new header
    streamPcm("R9 pre2", 2, 2, 5);
    loadHeader(32'h0F0F_12C4);
    streamPcm("R9 new header", 2, 0, 33);
  endtask

  task automatic testClamp();
    // R10
    numCh = 4'd0;
    restartBlock();
    streamPcm("R10 clamp low", 2, 0, 2);
    numCh = 4'd15;
    restartBlock();
    streamPcm("R10 clamp high", 8, 0, 2);
  endtask

  task automatic testPass();
    // R7: pass-through with each preamble code
    logic [31:0] w;
    logic [3:0] pre [3];
    pre[0] = 4'h8; pre[1] = 4'h4; pre[2] = 4'h2;
    modeSel = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      w = {4'(9 + i), 24'hC0FFEE ^ 24'(i * 4097), pre[i]};
      inValid = 1'b1; inData = w;
      #1;
      check("R7 pass map", outData, {3'b000, w[3], w[31:4]});
    end
    @(negedge clk);
    inValid = 1'b0; modeSel = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    testReset();
    rst_n = 1'b1;
    testFullBlock();
    testEightCh();
    testStall();
    testRestartMid();
    testClamp();
    testPass();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule